// File: doc/BRIEF.md
# Paged Packet Buffer Formatter

The block moves packets between a byte-wide RAM and two byte streams. The RAM holds a number of 256-byte pages. Each packet occupies one page, or two adjacent pages when long packets are allowed. In that page the header comes first: the sender ID, then the destination ID, then a count byte. The count byte gives the offset of the first data byte rather than the length. The data therefore always ends on the last byte of the page, or of the page pair.

To transmit, a host picks a page and whether long packets are allowed, then pulses `tx_start`. The block stamps the local node ID into the sender byte and reads the destination and count bytes. It decodes the start offset and the length, then sends the data bytes over a ready/valid stream. To receive, the host pulses `rx_start`. The block takes the incoming header and data bytes from a second stream and writes them into the page in the same layout. A received packet can therefore be sent again from the same page. When an operation ends, a one-cycle `done` pulse is raised together with an error flag or a receive-complete flag.

Top module: `paged_pkt_formatter`

## Requirements
- R1: After reset, `busy`, `out_valid`, `in_ready`, `ram_we` and `done` are all low.
- R2: A transmit first writes `node_id` into offset 0 of the selected page, before any data byte is streamed.
- R3: On transmit, the byte at offset 1 is reported on `hdr_did`. `hdr_bcast` is high exactly when that byte is 0.
- R4: For a short packet, the count byte at offset 2 holds a start offset c. The stream carries page offsets c..255 in address order, `hdr_len` is 256 − c, and `out_last` marks the final byte only.
- R5: With `long_mode` high and the offset-2 byte equal to 0, offset 3 holds c3. The data runs from page offset c3 to offset 511, across the selected page and the next one, with length 512 − c3. A nonzero offset-2 byte in long mode is decoded as a short packet.
- R6: A short count below 3 (length above 253 or 0) is illegal, and so is a long count c3 below 4 (length above 508). The operation then ends with `len_err`. A transmit streams no byte, and a receive writes no data byte.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` stay unchanged.
- R8: A receive writes the accepted bytes in order to offset 0 (sender), offset 1 (destination), offset 2 and, for a long packet, offset 3. It then writes the data bytes to consecutive addresses starting at the decoded start offset.
- R9: A receive ends after the byte flagged by `in_last` has been accepted. In the data phase it ends with `rx_ok` high. If `in_last` comes during the header, it ends with `len_err` instead.
- R10: `done` lasts exactly one cycle per operation. `len_err` and `rx_ok` are high only while `done` is high.
- R11: A start pulse while `busy` is high has no effect. If `tx_start` and `rx_start` come in the same cycle, the transmit runs and the receive is dropped.
- R12: A packet received into a page and then transmitted from that page yields the same data bytes, length and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| page_sel | input | PAGE_W | Page used by the next start |
| long_mode | input | 1 | Allow two-page packets |
| node_id | input | 8 | Local node ID stamped on transmit |
| tx_start | input | 1 | Start a transmit |
| rx_start | input | 1 | Start a receive |
| busy | output | 1 | An operation is in progress |
| ram_addr | output | PAGE_W+8 | RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the address |
| out_valid | output | 1 | Transmit byte valid |
| out_ready | input | 1 | Transmit byte accepted |
| out_data | output | 8 | Transmit data byte |
| out_last | output | 1 | Final transmit byte |
| in_valid | input | 1 | Receive byte valid |
| in_ready | output | 1 | Block accepts receive bytes |
| in_data | input | 8 | Receive byte (header, then data) |
| in_last | input | 1 | Final receive byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| len_err | output | 1 | Illegal count or truncated header, with done |
| rx_ok | output | 1 | Packet received and written, with done |
| hdr_did | output | 8 | Destination ID of the last packet |
| hdr_bcast | output | 1 | Destination ID is zero |
| hdr_len | output | 10 | Decoded data length |

## Verification
The assertions check several things on every cycle: output bytes are held while the stream is stalled, the two engines are never busy together, and the RAM is never written while idle. They also check that a transmit opens with the sender-ID write, that an accepted final byte produces a clean completion, and that error and receive-complete flags appear only with a one-cycle done. The directed scenarios show the rest, which depends on RAM contents. That covers the offset decoding for short, long and long-mode-short packets, data spanning two pages, and the exact bytes written on receive. It also covers rejection of the boundary counts, dropped starts while busy, and the receive-then-retransmit round trip.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned OFF_W         = 9;
  localparam int unsigned LEN_W         = 10;
  localparam int unsigned SHORT_MIN_CNT = 3;
  localparam int unsigned LONG_MIN_CNT  = 4;

  typedef enum logic [3:0] {
    TX_IDLE, TX_SID, TX_A1, TX_A2, TX_C2, TX_C3, TX_FETCH, TX_LOAD, TX_SEND
  } tx_state_e;

  typedef enum logic [2:0] {
    RX_IDLE, RX_SID, RX_DID, RX_CNT, RX_CNT3, RX_DATA, RX_DROP
  } rx_state_e;

  // count byte legality: ext selects the second (long) count byte
  function automatic logic cnt_legal(input logic [BYTE_W-1:0] c, input logic ext);
    return ext ? (c >= BYTE_W'(LONG_MIN_CNT)) : (c >= BYTE_W'(SHORT_MIN_CNT));
  endfunction

  // data length: bytes from the start offset to the end of one or two pages
  function automatic logic [LEN_W-1:0] span_len(input logic [BYTE_W-1:0] c, input logic ext);
    return (ext ? LEN_W'(512) : LEN_W'(256)) - LEN_W'(c);
  endfunction
endpackage

// File: rtl/pbf_hdr_decode.sv
module pbf_hdr_decode
  import pbf_pkg::*;
(
  input  logic [BYTE_W-1:0] cnt,
  input  logic              long_en,
  input  logic              ext,
  output logic              need_ext,
  output logic              legal,
  output logic [OFF_W-1:0]  start_off,
  output logic [LEN_W-1:0]  data_len
);
  always_comb begin
    need_ext  = !ext && long_en && (cnt == '0);
    legal     = cnt_legal(cnt, ext);
    start_off = OFF_W'(cnt);
    data_len  = span_len(cnt, ext);
  end
endmodule

// File: rtl/pbf_tx.sv
module pbf_tx
  import pbf_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  input  logic              long_en,
  input  logic [BYTE_W-1:0] node_id,
  output logic [PAGE_W+7:0] ram_addr,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              done,
  output logic              err,
  output logic [BYTE_W-1:0] hdr_did,
  output logic [LEN_W-1:0]  hdr_len
);
  localparam int ADDR_W = PAGE_W + 8;

  tx_state_e         st;
  logic [PAGE_W-1:0] page_q;
  logic              long_q;
  logic [OFF_W-1:0]  ptr, off;
  logic [LEN_W-1:0]  remain, len_q;
  logic [BYTE_W-1:0] did_q, dat_q;
  logic              done_q, err_q;
  logic              need_ext, legal;
  logic [OFF_W-1:0]  start_off;
  logic [LEN_W-1:0]  data_len;
  logic              tx_fire;

  pbf_hdr_decode u_dec (
    .cnt(ram_rdata), .long_en(long_q), .ext(st == TX_C3),
    .need_ext(need_ext), .legal(legal), .start_off(start_off), .data_len(data_len)
  );

  always_comb begin
    unique case (st)
      TX_SID:  off = OFF_W'(0);
      TX_A1:   off = OFF_W'(1);
      TX_A2:   off = OFF_W'(2);
      TX_C2:   off = OFF_W'(3);
      TX_SEND: off = ptr + OFF_W'(1);
      default: off = ptr;
    endcase
  end

  assign ram_addr  = ADDR_W'({page_q, 8'h00}) + ADDR_W'(off);
  assign ram_we    = (st == TX_SID);
  assign ram_wdata = node_id;
  assign busy      = (st != TX_IDLE);
  assign out_valid = (st == TX_SEND);
  assign out_data  = dat_q;
  assign out_last  = (remain == LEN_W'(1));
  assign tx_fire   = out_valid && out_ready;
  assign done      = done_q;
  assign err       = err_q;
  assign hdr_did   = did_q;
  assign hdr_len   = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= TX_IDLE; page_q <= '0; long_q <= 1'b0; ptr <= '0; remain <= '0;
      len_q <= '0; did_q <= '0; dat_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (st)
        TX_IDLE: if (start) begin
          page_q <= page; long_q <= long_en; st <= TX_SID;
        end
        TX_SID: st <= TX_A1;
        TX_A1:  st <= TX_A2;
        TX_A2: begin did_q <= ram_rdata; st <= TX_C2; end
        TX_C2, TX_C3: begin
          if (need_ext) st <= TX_C3;
          else if (!legal) begin
            len_q <= '0; done_q <= 1'b1; err_q <= 1'b1; st <= TX_IDLE;
          end else begin
            ptr <= start_off; remain <= data_len; len_q <= data_len; st <= TX_FETCH;
          end
        end
        TX_FETCH: st <= TX_LOAD;
        TX_LOAD: begin dat_q <= ram_rdata; st <= TX_SEND; end
        TX_SEND: if (out_ready) begin
          if (out_last) begin done_q <= 1'b1; st <= TX_IDLE; end
          else begin ptr <= ptr + OFF_W'(1); remain <= remain - LEN_W'(1); st <= TX_LOAD; end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // R2
  sid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ram_we);
  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R4
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire && out_last |=> done && !err);
endmodule

// File: rtl/pbf_rx.sv
module pbf_rx
  import pbf_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  input  logic              long_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic [PAGE_W+7:0] ram_addr,
  output logic              ram_we,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              ok,
  output logic [BYTE_W-1:0] hdr_did,
  output logic [LEN_W-1:0]  hdr_len
);
  localparam int ADDR_W = PAGE_W + 8;

  rx_state_e         st;
  logic [PAGE_W-1:0] page_q;
  logic              long_q;
  logic [OFF_W-1:0]  ptr, off;
  logic [LEN_W-1:0]  len_q;
  logic [BYTE_W-1:0] did_q;
  logic              done_q, err_q, ok_q;
  logic              need_ext, legal;
  logic [OFF_W-1:0]  start_off;
  logic [LEN_W-1:0]  data_len;

  pbf_hdr_decode u_dec (
    .cnt(in_data), .long_en(long_q), .ext(st == RX_CNT3),
    .need_ext(need_ext), .legal(legal), .start_off(start_off), .data_len(data_len)
  );

  always_comb begin
    unique case (st)
      RX_SID:  off = OFF_W'(0);
      RX_DID:  off = OFF_W'(1);
      RX_CNT:  off = OFF_W'(2);
      RX_CNT3: off = OFF_W'(3);
      default: off = ptr;
    endcase
  end

  assign in_ready  = (st != RX_IDLE);
  assign busy      = in_ready;
  assign ram_addr  = ADDR_W'({page_q, 8'h00}) + ADDR_W'(off);
  assign ram_we    = in_valid && in_ready && (st != RX_DROP);
  assign ram_wdata = in_data;
  assign done      = done_q;
  assign err       = err_q;
  assign ok        = ok_q;
  assign hdr_did   = did_q;
  assign hdr_len   = len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RX_IDLE; page_q <= '0; long_q <= 1'b0; ptr <= '0; len_q <= '0;
      did_q <= '0; done_q <= 1'b0; err_q <= 1'b0; ok_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ok_q   <= 1'b0;
      if (st == RX_IDLE) begin
        if (start) begin page_q <= page; long_q <= long_en; st <= RX_SID; end
      end else if (in_valid) begin
        unique case (st)
          RX_SID:
            if (in_last) begin done_q <= 1'b1; err_q <= 1'b1; st <= RX_IDLE; end
            else st <= RX_DID;
          RX_DID: begin
            did_q <= in_data;
            if (in_last) begin done_q <= 1'b1; err_q <= 1'b1; st <= RX_IDLE; end
            else st <= RX_CNT;
          end
          RX_CNT, RX_CNT3: begin
            if (in_last) begin done_q <= 1'b1; err_q <= 1'b1; st <= RX_IDLE; end
            else if (need_ext) st <= RX_CNT3;
            else if (!legal) begin len_q <= '0; st <= RX_DROP; end
            else begin ptr <= start_off; len_q <= data_len; st <= RX_DATA; end
          end
          RX_DATA: begin
            ptr <= ptr + OFF_W'(1);
            if (in_last) begin done_q <= 1'b1; ok_q <= 1'b1; st <= RX_IDLE; end
          end
          RX_DROP:
            if (in_last) begin done_q <= 1'b1; err_q <= 1'b1; st <= RX_IDLE; end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  ok_excl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> !err);
endmodule

// File: rtl/paged_pkt_formatter.sv
module paged_pkt_formatter
  import pbf_pkg::*;
#(
  parameter int NUM_PAGES = 8,
  parameter int PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              long_mode,
  input  logic [7:0]        node_id,
  input  logic              tx_start,
  input  logic              rx_start,
  output logic              busy,
  output logic [PAGE_W+7:0] ram_addr,
  output logic              ram_we,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              done,
  output logic              len_err,
  output logic              rx_ok,
  output logic [7:0]        hdr_did,
  output logic              hdr_bcast,
  output logic [9:0]        hdr_len
);
  localparam int ADDR_W = PAGE_W + 8;

  logic              tx_go, rx_go, tx_busy, rx_busy, sel_rx;
  logic [ADDR_W-1:0] tx_addr, rx_addr;
  logic              tx_we, rx_we, tx_done, rx_done, tx_err, rx_err, rx_ok_e;
  logic [7:0]        tx_wdata, rx_wdata, tx_did, rx_did;
  logic [LEN_W-1:0]  tx_len, rx_len;

  assign busy  = tx_busy || rx_busy;
  assign tx_go = tx_start && !busy;
  assign rx_go = rx_start && !busy && !tx_start;

  pbf_tx #(.PAGE_W(PAGE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_go), .page(page_sel), .long_en(long_mode),
    .node_id(node_id), .ram_addr(tx_addr), .ram_we(tx_we), .ram_wdata(tx_wdata),
    .ram_rdata(ram_rdata), .busy(tx_busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .done(tx_done), .err(tx_err),
    .hdr_did(tx_did), .hdr_len(tx_len)
  );

  pbf_rx #(.PAGE_W(PAGE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(rx_go), .page(page_sel), .long_en(long_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .ram_addr(rx_addr), .ram_we(rx_we), .ram_wdata(rx_wdata), .busy(rx_busy),
    .done(rx_done), .err(rx_err), .ok(rx_ok_e), .hdr_did(rx_did), .hdr_len(rx_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     sel_rx <= 1'b0;
    else if (tx_go) sel_rx <= 1'b0;
    else if (rx_go) sel_rx <= 1'b1;
  end

  assign ram_addr  = rx_busy ? rx_addr  : tx_addr;
  assign ram_we    = rx_busy ? rx_we    : tx_we;
  assign ram_wdata = rx_busy ? rx_wdata : tx_wdata;
  assign done      = tx_done || rx_done;
  assign len_err   = tx_err || rx_err;
  assign rx_ok     = rx_ok_e;
  assign hdr_did   = sel_rx ? rx_did : tx_did;
  assign hdr_len   = sel_rx ? rx_len : tx_len;
  assign hdr_bcast = (hdr_did == 8'h00);

  // R11
  one_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_busy, rx_busy}));
  // R10
  flags_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err || rx_ok) |-> done);
  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_we);
endmodule

// File: tb/paged_pkt_formatter_test.sv
`timescale 1ns/1ps
module paged_pkt_formatter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] page_sel = '0;
  logic long_mode = 1'b0, tx_start = 1'b0, rx_start = 1'b0;
  logic [7:0] node_id = 8'h3C;
  logic busy, ram_we, out_valid, out_last, in_ready, done, len_err, rx_ok, hdr_bcast;
  logic out_ready = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [10:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata, out_data, hdr_did;
  logic [7:0] in_data = '0;
  logic [9:0] hdr_len;

  always #2 clk = ~clk;

  paged_pkt_formatter uut (
    .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .long_mode(long_mode), .node_id(node_id),
    .tx_start(tx_start), .rx_start(rx_start), .busy(busy), .ram_addr(ram_addr),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last), .done(done),
    .len_err(len_err), .rx_ok(rx_ok), .hdr_did(hdr_did), .hdr_bcast(hdr_bcast),
    .hdr_len(hdr_len)
  );

  logic [7:0] mem [0:2047];
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  int n_chk = 0, n_bad = 0, done_cnt = 0;
  logic last_err = 1'b0, last_ok = 1'b0;
  always @(posedge clk) if (rst_n && done) begin
    done_cnt <= done_cnt + 1; last_err <= len_err; last_ok <= rx_ok;
  end

  logic [7:0] cap [0:599];
  logic [7:0] pkt [0:599];
  int cap_n, last_at, saw_in_ready;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_page(input int pg, input int seed);
    for (int i = 0; i < 256; i++) mem[pg*256 + i] = 8'((i*7 + seed) & 255);
  endtask

  task automatic run_tx(input int pg, input bit lm, input bit stall, input bit poke);
    int d0 = done_cnt;
    cap_n = 0; last_at = -1; saw_in_ready = 0;
    @(negedge clk); page_sel = 3'(pg); long_mode = lm; tx_start = 1'b1; rx_start = poke;
    @(negedge clk); tx_start = 1'b0;
    for (int cyc = 0; cyc < 3000 && done_cnt == d0; cyc++) begin
      rx_start = poke && (cyc < 5);
      out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (in_ready) saw_in_ready++;
      if (out_valid && out_ready) begin
        cap[cap_n] = out_data;
        if (out_last) last_at = cap_n;
        cap_n++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0; rx_start = 1'b0;
    chk("R10 one done per transmit", done_cnt - d0, 1);
  endtask

  task automatic check_stream(input string req, input int first_addr, input int len);
    int bad = 0;
    chk(req, cap_n, len);
    for (int i = 0; i < len && i < cap_n; i++)
      if (cap[i] != mem[(first_addr + i) & 2047]) bad++;
    chk(req, bad, 0);
    chk(req, last_at, len - 1);
  endtask

  task automatic run_rx(input int pg, input bit lm, input int n);
    int d0 = done_cnt;
    @(negedge clk); page_sel = 3'(pg); long_mode = lm; rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 one done per receive", done_cnt - d0, 1);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 0); chk("R1 ram_we", ram_we, 0); chk("R1 done", done, 0);
  endtask

  task automatic t_tx_short();
    fill_page(2, 1); mem[512] = 8'hEE; mem[513] = 8'h05; mem[514] = 8'd252;
    run_tx(2, 0, 0, 0);
    chk("R2 sender stamped", mem[512], 8'h3C);
    chk("R3 did", hdr_did, 5); chk("R3 bcast", hdr_bcast, 0);
    chk("R4 len", hdr_len, 4); chk("R4 no error", last_err, 0);
    check_stream("R4 short data", 512 + 252, 4);
  endtask

  task automatic t_tx_stall();
    fill_page(3, 9); mem[769] = 8'h44; mem[770] = 8'd240;
    run_tx(3, 0, 1, 0);
    check_stream("R7 stalled stream", 768 + 240, 16);
  endtask

  task automatic t_tx_long();
    fill_page(4, 3); fill_page(5, 77); mem[1025] = 8'h00; mem[1026] = 8'h00; mem[1027] = 8'd4;
    run_tx(4, 1, 0, 0);
    chk("R5 long len", hdr_len, 508); chk("R3 broadcast", hdr_bcast, 1);
    check_stream("R5 two-page data", 1024 + 4, 508);
    fill_page(0, 5); mem[1] = 8'h12; mem[2] = 8'd200;
    run_tx(0, 1, 0, 0);
    chk("R5 long mode short len", hdr_len, 56);
    check_stream("R5 long mode short data", 200, 56);
  endtask

  task automatic t_tx_err();
    mem[1282] = 8'd2;
    run_tx(5, 0, 0, 0);
    chk("R6 short count 2 err", last_err, 1); chk("R6 no bytes", cap_n, 0);
    mem[1282] = 8'd0;
    run_tx(5, 0, 0, 0);
    chk("R6 short count 0 err", last_err, 1); chk("R6 no bytes", cap_n, 0);
    mem[1538] = 8'd0; mem[1539] = 8'd3;
    run_tx(6, 1, 0, 0);
    chk("R6 long count 3 err", last_err, 1); chk("R6 no bytes", cap_n, 0);
    mem[1282] = 8'd3;
    run_tx(5, 0, 0, 0);
    chk("R6 short count 3 legal", last_err, 0); chk("R6 253 bytes", cap_n, 253);
  endtask

  task automatic t_rx_short();
    int bad = 0;
    fill_page(1, 0);
    pkt[0] = 8'h21; pkt[1] = 8'h07; pkt[2] = 8'd250;
    for (int i = 0; i < 6; i++) pkt[3+i] = 8'(8'hB0 + i);
    run_rx(1, 0, 9);
    chk("R9 rx_ok", last_ok, 1); chk("R9 no err", last_err, 0); chk("R9 len", hdr_len, 6);
    chk("R8 sid", mem[256], 8'h21); chk("R8 did", mem[257], 8'h07); chk("R8 cnt", mem[258], 250);
    for (int i = 0; i < 6; i++) if (mem[256 + 250 + i] != pkt[3+i]) bad++;
    chk("R8 data placement", bad, 0);
  endtask

  task automatic t_retx();
    run_tx(1, 0, 0, 0);
    chk("R12 did", hdr_did, 7); chk("R12 len", hdr_len, 6);
    check_stream("R12 retransmit data", 256 + 250, 6);
    chk("R12 first byte", cap[0], 8'hB0);
  endtask

  task automatic t_rx_long();
    int bad = 0;
    pkt[0] = 8'h11; pkt[1] = 8'h00; pkt[2] = 8'h00; pkt[3] = 8'd200;
    for (int i = 0; i < 312; i++) pkt[4+i] = 8'((i*13 + 1) & 255);
    run_rx(6, 1, 316);
    chk("R9 long rx_ok", last_ok, 1); chk("R5 long rx len", hdr_len, 312);
    chk("R8 second count", mem[1539], 200); chk("R3 rx bcast", hdr_bcast, 1);
    for (int i = 0; i < 312; i++) if (mem[1536 + 200 + i] != pkt[4+i]) bad++;
    chk("R8 two-page placement", bad, 0);
  endtask

  task automatic t_rx_err();
    int bad = 0;
    for (int i = 0; i < 256; i++) mem[1792 + i] = 8'h5A;
    pkt[0] = 8'h01; pkt[1] = 8'h02; pkt[2] = 8'd1; pkt[3] = 8'h91; pkt[4] = 8'h92; pkt[5] = 8'h93;
    run_rx(7, 0, 6);
    chk("R6 rx err", last_err, 1); chk("R9 no rx_ok", last_ok, 0);
    chk("R8 count written", mem[1794], 1);
    for (int i = 3; i < 256; i++) if (mem[1792 + i] != 8'h5A) bad++;
    chk("R6 no data written", bad, 0);
    pkt[0] = 8'h09; pkt[1] = 8'h09;
    run_rx(7, 0, 2);
    chk("R9 header truncated err", last_err, 1); chk("R9 header truncated ok", last_ok, 0);
  endtask

  task automatic t_busy();
    run_tx(2, 0, 0, 1);
    chk("R11 rx start ignored", saw_in_ready, 0);
    check_stream("R11 tx unaffected", 512 + 252, 4);
    chk("R11 idle after", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_tx_short();
    t_tx_stall();
    t_tx_long();
    t_tx_err();
    t_rx_short();
    t_retx();
    t_rx_long();
    t_rx_err();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule